// File: doc/BRIEF.md
# Programmable timer channel

One 16-bit timer channel with a loadable reload register and an 8-bit control word. In its waveform modes the channel drives a square wave or a single pulse on its output pin. The count runs either as one 16-bit down-counter or as two cascaded 8-bit counters. In that second form the low byte acts as a prescaler and the output duty is asymmetric. In its measurement modes the channel times the interval between gate edges. It raises its flag when that interval ends before, or after, the counter's timeout.

Each count tick is either a falling edge on the external clock pin or a cycle on which the internal enable is high. The gate and the external clock must already be synchronous to `clk`. All pins are plain control or status levels. The reload strobe is a one-cycle write with no handshake and no back-pressure, and the channel accepts it on every cycle. The flag and initialisation outputs are one-cycle pulses.

Top module: `tmr_channel`

## Requirements
- R1: After `rst_n` is released, `count`, `tmr_out`, `flag_set` and `init_pulse` are all 0.
- R2: `ctrl[1]`=0 counts falling edges of `ext_clk_n` and ignores its rising edges and `tick_en`. `ctrl[1]`=1 counts each cycle with `tick_en`=1. With no tick, `count` holds.
- R3: With `ctrl[5:3]`=000 or 010 and `ctrl[2]`=0 (continuous, 16-bit), `count` steps N, N-1, ..., 0. The next tick is the timeout: the wave toggles, starting low after an initialisation, and `flag_set` pulses. The wave therefore changes every N+1 ticks.
- R4: In waveform modes (`ctrl[3]`=0) an initialisation loads `count` from the reload value and pulses `init_pulse`. It is caused by a gate falling edge, or by a reload write when `ctrl[4]`=0. A reload write with `ctrl[4]`=1 does not initialise.
- R5: At timeout the counter reloads from the most recently written reload value.
- R6: With `ctrl[2]`=1 the low byte L prescales the high byte M. The period is (L+1)*(M+1) ticks. The wave is high for the final L ticks of each period.
- R7: With `ctrl[5:3]`=100 or 110 (single shot), the wave is low for 1 tick after initialisation, then high for N ticks. It goes low at timeout and stays low until the next initialisation.
- R8: While `preset` is 1 the counter is reloaded every cycle, `init_pulse` is 1 and `tmr_out` is 0.
- R9: `tmr_out` is the wave when `ctrl[7]`=1 and 0 when `ctrl[7]`=0. `flag_set` is not affected by `ctrl[7]`.
- R10: With `ctrl[4:3]`=01 (frequency compare) a gate falling edge starts counting from the reload value. With `ctrl[5]`=0 the next falling edge pulses `flag_set` when no timeout came first; otherwise it restarts the count. With `ctrl[5]`=1 the flag condition is inverted.
- R11: With `ctrl[4:3]`=11 (pulse-width compare) counting runs from a gate falling edge to the gate rising edge. With `ctrl[5]`=0 the rising edge pulses `flag_set` when no timeout came first; `ctrl[5]`=1 inverts this.
- R12: After a measurement flag, counting stops and gate edges are ignored until a reload write or `preset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 8 | Control word |
| latch_val | input | 16 | Reload value |
| latch_wr | input | 1 | One-cycle reload write strobe |
| preset | input | 1 | Hold channel in preset state |
| tick_en | input | 1 | Internal count enable |
| ext_clk_n | input | 1 | External count clock, active low |
| gate_n | input | 1 | Gate, active low |
| tmr_out | output | 1 | Timer output pin |
| flag_set | output | 1 | One-cycle interrupt flag set pulse |
| init_pulse | output | 1 | One-cycle counter initialisation pulse |
| count | output | 16 | Live counter value |

## Verification
Every result is registered. A stimulus driven in one cycle therefore shows on `count`, `flag_set`, `init_pulse` and `tmr_out` one cycle later. The exception is the `ctrl[7]` mask, which acts on `tmr_out` in the same cycle. A timeout falls N+1 ticks after the counter was loaded. Each scripted stimulus files its expected values with the exact cycle index at which they are due. The comparison process matches each entry against the outputs sampled mid-cycle at that index.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {MD_CONT, MD_SHOT, MD_FREQ, MD_PWID} tmr_mode_e;

  typedef struct packed {
    logic      out_en;
    tmr_mode_e mode;
    logic      late;
    logic      gate_only;
    logic      dual;
    logic      int_tick;
  } tmr_cfg_t;

  function automatic tmr_cfg_t decode_ctrl(input logic [7:0] c);
    tmr_cfg_t r;
    r.out_en    = c[7];
    r.late      = c[5];
    r.gate_only = c[4];
    r.dual      = c[2];
    r.int_tick  = c[1];
    if (!c[3]) r.mode = c[5] ? MD_SHOT : MD_CONT;
    else       r.mode = c[4] ? MD_PWID : MD_FREQ;
    return r;
  endfunction
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= sig_n;
  end

  assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             tick,
  input  logic             dual,
  input  logic             latch_wr,
  input  logic [WIDTH-1:0] latch_val,
  output logic [WIDTH-1:0] cnt,
  output logic             to_evt,
  output logic             hi_zero,
  output logic             lo_zero
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] latch_q, cnt_q, load_v;
  logic [HALF-1:0]  lo, hi;
  logic             zero;

  assign load_v  = latch_wr ? latch_val : latch_q;
  assign lo      = cnt_q[HALF-1:0];
  assign hi      = cnt_q[WIDTH-1:HALF];
  assign lo_zero = (lo == '0);
  assign hi_zero = (hi == '0);
  assign zero    = lo_zero & hi_zero;
  assign to_evt  = tick & ~init & zero;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (latch_wr) latch_q <= latch_val;
      if (init) begin
        cnt_q <= load_v;
      end else if (tick) begin
        if (!dual) begin
          cnt_q <= zero ? load_v : cnt_q - 1'b1;
        end else if (lo_zero) begin
          cnt_q[HALF-1:0]     <= load_v[HALF-1:0];
          cnt_q[WIDTH-1:HALF] <= hi_zero ? load_v[WIDTH-1:HALF] : hi - 1'b1;
        end else begin
          cnt_q[HALF-1:0] <= lo - 1'b1;
        end
      end
    end
  end

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && tick && !dual && !zero) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !tick) |=> $stable(cnt_q));
  p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> cnt_q == $past(load_v));
  p_timeout_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (to_evt && !dual) |=> cnt_q == $past(load_v));
endmodule

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e mode,
  input  logic      late,
  input  logic      gate_only,
  input  logic      dual,
  input  logic      preset,
  input  logic      latch_wr,
  input  logic      g_fall,
  input  logic      g_rise,
  input  logic      tick_raw,
  input  logic      to_evt,
  input  logic      hi_zero,
  input  logic      lo_zero,
  output logic      init,
  output logic      cnt_tick,
  output logic      flag_set,
  output logic      init_pulse,
  output logic      wave
);
  logic meas, pw, single, hit, stop_c;
  logic init_wave, init_meas, flag_meas, flag_c;
  logic ce_q, hold_q, seen_q, wave_q, done_q, held_q, flag_q, init_q;

  assign meas   = (mode == MD_FREQ) || (mode == MD_PWID);
  assign pw     = (mode == MD_PWID);
  assign single = (mode == MD_SHOT);
  assign hit    = late ? seen_q : ~seen_q;
  assign stop_c = preset | latch_wr;

  assign cnt_tick  = tick_raw & (~meas | ce_q);
  assign init_wave = ~meas & (g_fall | (latch_wr & ~gate_only));
  assign init_meas = meas & g_fall & ~hold_q & ~latch_wr & ~(~pw & ce_q & hit);
  assign init      = preset | init_wave | init_meas;
  assign flag_meas = meas & ~stop_c & ~hold_q & ce_q & hit & (pw ? g_rise : g_fall);
  assign flag_c    = (~meas & to_evt) | flag_meas;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q <= 1'b0; hold_q <= 1'b0; seen_q <= 1'b0; wave_q <= 1'b0;
      done_q <= 1'b0; held_q <= 1'b0; flag_q <= 1'b0; init_q <= 1'b0;
    end else begin
      flag_q <= flag_c;
      init_q <= init;
      held_q <= preset;
      if (stop_c || !meas || flag_meas)    ce_q <= 1'b0;
      else if (init_meas)                  ce_q <= 1'b1;
      else if (pw && g_rise)               ce_q <= 1'b0;
      if (stop_c || !meas)                 hold_q <= 1'b0;
      else if (flag_meas)                  hold_q <= 1'b1;
      if (init)                            seen_q <= 1'b0;
      else if (to_evt && meas)             seen_q <= 1'b1;
      if (init) begin
        wave_q <= 1'b0;
        done_q <= 1'b0;
      end else if (cnt_tick && !meas) begin
        if (to_evt) begin
          if (single) begin
            wave_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            wave_q <= ~wave_q;
          end
        end else if (single && !done_q) begin
          wave_q <= 1'b1;
        end
      end
    end
  end

  assign wave = ~held_q & ~meas &
                (dual ? (hi_zero & ~lo_zero & ~(single & done_q)) : wave_q);
  assign flag_set   = flag_q;
  assign init_pulse = init_q;

  p_preset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (!wave && init_pulse));
  p_idle_after_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && meas && !stop_c) |=> !ce_q);
  p_shot_stays_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (single && done_q && !init) |=> (!wave || !single));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctrl,
  input  logic [WIDTH-1:0] latch_val,
  input  logic             latch_wr,
  input  logic             preset,
  input  logic             tick_en,
  input  logic             ext_clk_n,
  input  logic             gate_n,
  output logic             tmr_out,
  output logic             flag_set,
  output logic             init_pulse,
  output logic [WIDTH-1:0] count
);
  localparam int         NEDGE = 3;
  localparam logic [2:0] IDLES = 3'b011;

  tmr_cfg_t         cfg;
  logic [NEDGE-1:0] edge_in, edge_fall;
  logic             tick_raw, init, cnt_tick, to_evt, hi_zero, lo_zero, wave;

  assign cfg     = decode_ctrl(ctrl);
  assign edge_in = {~gate_n, gate_n, ext_clk_n};

  for (genvar i = 0; i < NEDGE; i++) begin : g_edge
    tmr_edge #(.IDLE(IDLES[i])) u_edge (
      .clk(clk), .rst_n(rst_n), .sig_n(edge_in[i]), .fall(edge_fall[i])
    );
  end

  assign tick_raw = cfg.int_tick ? tick_en : edge_fall[0];

  tmr_mode_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .late(cfg.late),
    .gate_only(cfg.gate_only), .dual(cfg.dual), .preset(preset),
    .latch_wr(latch_wr), .g_fall(edge_fall[1]), .g_rise(edge_fall[2]),
    .tick_raw(tick_raw), .to_evt(to_evt), .hi_zero(hi_zero), .lo_zero(lo_zero),
    .init(init), .cnt_tick(cnt_tick), .flag_set(flag_set),
    .init_pulse(init_pulse), .wave(wave)
  );

  tmr_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .init(init), .tick(cnt_tick), .dual(cfg.dual),
    .latch_wr(latch_wr), .latch_val(latch_val), .cnt(count),
    .to_evt(to_evt), .hi_zero(hi_zero), .lo_zero(lo_zero)
  );

  assign tmr_out = cfg.out_en & wave;
endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n, latch_wr, preset, tick_en, ext_clk_n, gate_n;
  logic [7:0]  ctrl;
  logic [15:0] latch_val;
  logic        tmr_out, flag_set, init_pulse;
  logic [15:0] count;

  typedef struct {int cyc; int sel; int val; string req;} exp_t;
  exp_t sb[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam int S_OUT = 0, S_CNT = 1, S_FLG = 2, S_INI = 3;

  tmr_channel dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .latch_val(latch_val),
    .latch_wr(latch_wr), .preset(preset), .tick_en(tick_en),
    .ext_clk_n(ext_clk_n), .gate_n(gate_n), .tmr_out(tmr_out),
    .flag_set(flag_set), .init_pulse(init_pulse), .count(count)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int obs(int sel);
    case (sel)
      S_OUT:   return int'(tmr_out);
      S_CNT:   return int'(count);
      S_FLG:   return int'(flag_set);
      default: return int'(init_pulse);
    endcase
  endfunction

  task automatic want(int dly, int sel, int val, string req);
    exp_t e;
    e.cyc = cyc + dly; e.sel = sel; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic go();
    @(negedge clk);
  endtask

  task automatic load(logic [7:0] c, logic [15:0] v);
    ctrl = c; latch_val = v; latch_wr = 1'b1;
  endtask

  // monitor: pops entries due in this cycle, mid-cycle
  always @(negedge clk) begin
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        n_chk++;
        if (obs(sb[i].sel) != sb[i].val) begin
          n_bad++;
          $display("FAIL %s sel=%0d cyc=%0d actual=%0d expected=%0d",
                   sb[i].req, sb[i].sel, cyc, obs(sb[i].sel), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    rst_n = 0; ctrl = 0; latch_val = 0; latch_wr = 0; preset = 0;
    tick_en = 1; ext_clk_n = 1; gate_n = 1;
    repeat (3) go();
    rst_n = 1;
    want(0, S_CNT, 0, "R1"); want(0, S_OUT, 0, "R1"); want(0, S_FLG, 0, "R1");
    want(2, S_CNT, 0, "R1"); want(2, S_INI, 0, "R1");
    repeat (3) go();

    // R3 continuous 16-bit, N=3, init by write (R4)
    load(8'h82, 16'd3);
    want(1, S_INI, 1, "R4"); want(1, S_CNT, 3, "R3"); want(4, S_CNT, 0, "R3");
    want(4, S_OUT, 0, "R3"); want(5, S_OUT, 1, "R3"); want(5, S_CNT, 3, "R5");
    want(5, S_FLG, 1, "R3"); want(6, S_FLG, 0, "R3");
    want(8, S_OUT, 1, "R3"); want(9, S_OUT, 0, "R3");
    go(); latch_wr = 0;
    repeat (10) go();

    // R8 preset, then R4 write without init when ctrl[4]=1, R5 reload
    ctrl = 8'h92; preset = 1;
    want(1, S_INI, 1, "R8"); want(2, S_INI, 1, "R8");
    want(2, S_OUT, 0, "R8"); want(2, S_CNT, 3, "R8");
    go(); go(); preset = 0;
    go(); latch_val = 16'd9; latch_wr = 1;
    want(1, S_INI, 0, "R4"); want(1, S_CNT, 1, "R4");
    want(2, S_CNT, 0, "R5"); want(3, S_CNT, 9, "R5");
    go(); latch_wr = 0;
    repeat (4) go();

    // R4 gate falling edge initialises
    ctrl = 8'h82; gate_n = 0;
    want(1, S_INI, 1, "R4"); want(1, S_CNT, 9, "R4"); want(2, S_CNT, 8, "R4");
    go(); gate_n = 1;
    repeat (4) go();

    // R7 single shot, N=2
    load(8'hA2, 16'd2);
    want(1, S_CNT, 2, "R7"); want(1, S_OUT, 0, "R7"); want(2, S_OUT, 1, "R7");
    want(3, S_OUT, 1, "R7"); want(4, S_OUT, 0, "R7"); want(4, S_FLG, 1, "R7");
    want(4, S_CNT, 2, "R7"); want(5, S_OUT, 0, "R7"); want(7, S_FLG, 1, "R7");
    want(8, S_OUT, 0, "R7");
    go(); latch_wr = 0;
    repeat (9) go();

    // R6 dual 8-bit, M=1 L=2
    load(8'h86, 16'h0102);
    want(1, S_CNT, 16'h0102, "R6"); want(1, S_OUT, 0, "R6");
    want(3, S_CNT, 16'h0100, "R6"); want(4, S_CNT, 16'h0002, "R6");
    want(4, S_OUT, 1, "R6"); want(5, S_OUT, 1, "R6"); want(6, S_OUT, 0, "R6");
    want(7, S_FLG, 1, "R6"); want(7, S_CNT, 16'h0102, "R6"); want(7, S_OUT, 0, "R6");
    go(); latch_wr = 0;
    repeat (8) go();

    // R2 external clock ticks
    load(8'h80, 16'd5);
    want(1, S_CNT, 5, "R2"); want(4, S_CNT, 5, "R2");
    go(); latch_wr = 0;
    repeat (3) go();
    ext_clk_n = 0;
    want(1, S_CNT, 4, "R2");
    go(); ext_clk_n = 1;
    want(2, S_CNT, 4, "R2");
    repeat (3) go();

    // R9 output mask
    load(8'h02, 16'd3);
    want(5, S_FLG, 1, "R9"); want(5, S_OUT, 0, "R9");
    go(); latch_wr = 0;
    repeat (5) go();
    ctrl = 8'h82;
    want(0, S_OUT, 1, "R9"); want(1, S_OUT, 1, "R9");
    repeat (2) go();

    // R10 frequency compare, early edge flags
    load(8'h0A, 16'd10);
    want(1, S_INI, 0, "R10");
    go(); latch_wr = 0;
    go(); gate_n = 0;
    want(1, S_INI, 1, "R10"); want(1, S_CNT, 10, "R10");
    go(); gate_n = 1;
    repeat (3) go();
    gate_n = 0;
    want(1, S_FLG, 1, "R10"); want(1, S_CNT, 6, "R10"); want(4, S_CNT, 6, "R12");
    go(); gate_n = 1;
    repeat (4) go();
    gate_n = 0;
    want(1, S_INI, 0, "R12"); want(1, S_CNT, 6, "R12"); want(1, S_FLG, 0, "R12");
    go(); gate_n = 1;
    go();

    // R10 late variant: early edge restarts, late edge flags
    load(8'h2A, 16'd5);
    go(); latch_wr = 0;
    go(); gate_n = 0;
    want(1, S_CNT, 5, "R10"); want(1, S_INI, 1, "R10");
    go(); gate_n = 1;
    go(); go();
    gate_n = 0;
    want(1, S_FLG, 0, "R10"); want(1, S_INI, 1, "R10"); want(1, S_CNT, 5, "R10");
    go(); gate_n = 1;
    repeat (8) go();
    gate_n = 0;
    want(1, S_FLG, 1, "R10");
    go(); gate_n = 1;
    go();

    // R11 pulse-width compare, rising edge before timeout
    load(8'h1A, 16'd6);
    go(); latch_wr = 0;
    go(); gate_n = 0;
    want(1, S_CNT, 6, "R11");
    repeat (3) go();
    gate_n = 1;
    want(1, S_FLG, 1, "R11"); want(1, S_CNT, 3, "R11"); want(3, S_CNT, 3, "R11");
    repeat (4) go();

    // R12 write re-arms measurement
    latch_val = 16'd7; latch_wr = 1;
    go(); latch_wr = 0;
    go(); gate_n = 0;
    want(1, S_INI, 1, "R12"); want(1, S_CNT, 7, "R12");
    go(); gate_n = 1;
    repeat (6) go();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule